// File: doc/BRIEF.md
# SPDIF Receive Frame Tracker

This block takes a biphase-mark coded serial audio line, oversamples it with the system clock at a fixed number of samples per half-bit, and turns it into audio samples. It measures the time between line transitions, classifies each run as one, two or three half-bits, recognises the three preamble kinds, decodes the 28 data slots that follow each preamble, and pushes the selected audio field into a small receive queue that the consumer drains with a pop strobe.

While it is receiving, the tracker also collects the channel-status bit of every left subframe into a 192-bit block register, counting frames from the block-start preamble. Four sticky status flags (bad preamble, block-start seen, status block complete, queue overrun) each have an interrupt enable and are cleared by a one-cycle pulse on the matching clear bit. A busy indication follows the receiver's lock state rather than the enable alone.

Top module: `spdif_rx_tracker`

## Requirements
- R1: `busy` stays 0 while `rx_en` is 1 and no preamble has arrived; it rises only after a valid preamble is decoded while `rx_en` is 1.
- R2: With `rx_en` low, `busy` falls when the next right subframe (third preamble kind) completes while the line stays active; subframes completing after that are not queued.
- R3: `busy` falls when the line shows no transition for 8 half-bit times (4 bit cells); it stays 1 over 3 quiet bit cells.
- R4: Preambles are recognised by run lengths in half-bits: block start 3,1,1,3; left 3,3,1,1; right 3,2,1,2. Each of the 28 following data bits is one cell with a mid-cell transition for 1. The first data bit is slot 4; slots 4..27 carry audio LSB first and slot 30 carries channel status.
- R5: With `cap_left`=1 the first queued sample after `busy` rises is a left subframe, with `cap_left`=0 a right one; every later subframe is then queued in order, `q_right`=1 marking right.
- R6: `mode` 0 queues slots 12..27, mode 1 slots 8..27, modes 2 and 3 slots 4..27, each right-justified and zero-extended in `q_data`.
- R7: `flags[1]` is set whenever a block-start preamble is decoded while `rx_en` is 1.
- R8: `flags[0]` is set when a preamble run pattern matches no kind or a run length is illegal; the subframe behind it is not queued.
- R9: The slot-30 bit of the left subframe of frame n (frame 0 begins with a block-start preamble) is stored in `cs_bits[n]`; right-subframe status bits are not stored. `flags[2]` is set when frame 191's left subframe completes, and not before.
- R10: A sample arriving with the queue holding DEPTH entries is dropped, older entries are kept, and `flags[3]` is set.
- R11: Every flag stays set until a one-cycle pulse on the same bit of `clr`; `irq` is the OR of `flags & ie`.
- R12: After reset `busy`, `flags`, `irq` and `q_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Biphase-mark coded serial line |
| rx_en | input | 1 | Receive enable |
| cap_left | input | 1 | 1: capture starts on left, 0: on right |
| mode | input | 2 | Sample width select (0:16, 1:20, 2/3:24 bits) |
| pop | input | 1 | Remove the head entry of the queue |
| q_valid | output | 1 | Queue holds at least one entry |
| q_data | output | 24 | Head sample, right-justified |
| q_right | output | 1 | Head sample came from a right subframe |
| q_level | output | LW | Number of queued entries |
| busy | output | 1 | Receiver locked and capturing |
| flags | output | 4 | Sticky flags: 0 bad preamble, 1 block start, 2 status block, 3 overrun |
| clr | input | 4 | Clear pulses, one per flag |
| ie | input | 4 | Interrupt enables, one per flag |
| irq | output | 1 | Interrupt request |
| cs_bits | output | 192 | Channel-status block, bit n from frame n |

## Verification
The hardest condition to reach is the completed status block: it needs an unbroken run of 192 frames that starts with a block-start preamble, with the flag checked still clear after frame 190 and set only after frame 191. The bench drives that full block with a computed status pattern in the left subframes and its complement in the right ones, so a tracker that stored the wrong channel or counted frames off by one gives a different vector. Separating the two ways busy can fall is also delicate; the frame-end case is checked while the line keeps toggling, and the inactivity case by checking busy both inside and after the quiet window.

// File: rtl/spdif_rx_tracker.sv
module spdif_rx_tracker #(
  parameter int HALF  = 4,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_in,
  input  logic           rx_en,
  input  logic           cap_left,
  input  logic [1:0]     mode,
  input  logic           pop,
  output logic           q_valid,
  output logic [23:0]    q_data,
  output logic           q_right,
  output logic [LW-1:0]  q_level,
  output logic           busy,
  output logic [3:0]     flags,
  input  logic [3:0]     clr,
  input  logic [3:0]     ie,
  output logic           irq,
  output logic [191:0]   cs_bits
);
  localparam int IDLE = 8 * HALF;
  localparam int CW   = $clog2(IDLE + 1);
  localparam int RW   = CW + 1;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [RW-1:0] TS = RW'((3 * HALF) / 2);
  localparam logic [RW-1:0] TM = RW'((5 * HALF) / 2);
  localparam logic [RW-1:0] TL = RW'((7 * HALF) / 2);
  localparam logic [1:0] K_S = 2'd0, K_M = 2'd1, K_L = 2'd2, K_X = 2'd3;
  localparam logic [1:0] P_B = 2'd0, P_M = 2'd1, P_W = 2'd2;

  typedef enum logic [1:0] {HUNT, PRE, DATA} st_t;

  logic [2:0]    sy;
  logic [CW-1:0] cnt;
  logic          edge_i, went_idle;
  logic [RW-1:0] len;
  logic [1:0]    kind;

  assign edge_i    = sy[2] ^ sy[1];
  assign went_idle = !edge_i && (cnt == CW'(IDLE - 1));
  assign len       = {1'b0, cnt} + RW'(1);
  assign kind      = (len < TS) ? K_S : (len < TM) ? K_M : (len < TL) ? K_L : K_X;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy  <= '0;
      cnt <= CW'(IDLE);
    end else begin
      sy <= {sy[1:0], line_in};
      if (edge_i) cnt <= '0;
      else if (cnt != CW'(IDLE)) cnt <= cnt + CW'(1);
    end

  st_t         st, st_n;
  logic [1:0]  pcnt, pcnt_n, pk, pk_n;
  logic [3:0]  pat, pat_n;
  logic [4:0]  bitn, bitn_n;
  logic        halfb, halfb_n;
  logic [27:0] sr, sr_n;
  logic        pre_ok, viol, sf_done, bit_v, bit_done;

  always_comb begin
    st_n = st; pcnt_n = pcnt; pat_n = pat; bitn_n = bitn;
    halfb_n = halfb; sr_n = sr; pk_n = pk;
    pre_ok = 1'b0; viol = 1'b0; sf_done = 1'b0; bit_v = 1'b0; bit_done = 1'b0;
    if (went_idle) st_n = HUNT;
    else if (edge_i) begin
      case (st)
        HUNT: if (kind == K_L) begin st_n = PRE; pcnt_n = 2'd1; end
        PRE: begin
          if (pcnt != 2'd3) begin
            pat_n  = {pat[1:0], kind};
            pcnt_n = pcnt + 2'd1;
            if (kind == K_X) begin viol = 1'b1; st_n = HUNT; end
          end else begin
            st_n = DATA; bitn_n = '0; halfb_n = 1'b0; pre_ok = 1'b1;
            case ({pat, kind})
              {K_S, K_S, K_L}: pk_n = P_B;
              {K_L, K_S, K_S}: pk_n = P_M;
              {K_M, K_S, K_M}: pk_n = P_W;
              default: begin pre_ok = 1'b0; viol = 1'b1; st_n = HUNT; end
            endcase
          end
        end
        DATA: begin
          if (bitn == 5'd28) begin
            if (kind == K_L) begin st_n = PRE; pcnt_n = 2'd1; end
            else begin viol = 1'b1; st_n = HUNT; end
          end else if (kind == K_S && !halfb) halfb_n = 1'b1;
          else if (kind == K_S || (kind == K_M && !halfb)) begin
            bit_done = 1'b1;
            bit_v    = (kind == K_S);
          end else begin viol = 1'b1; st_n = HUNT; end
        end
        default: st_n = HUNT;
      endcase
    end
    if (bit_done) begin
      sr_n    = {bit_v, sr[27:1]};
      halfb_n = 1'b0;
      bitn_n  = bitn + 5'd1;
      sf_done = (bitn == 5'd27);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= HUNT; pcnt <= '0; pat <= '0; bitn <= '0;
      halfb <= 1'b0; sr <= '0; pk <= P_M;
    end else begin
      st <= st_n; pcnt <= pcnt_n; pat <= pat_n; bitn <= bitn_n;
      halfb <= halfb_n; sr <= sr_n; pk <= pk_n;
    end

  logic [23:0] aud, smp;
  logic        right;
  assign aud   = sr_n[23:0];
  assign right = (pk == P_W);
  always_comb
    case (mode)
      2'd0:    smp = {8'd0, aud[23:8]};
      2'd1:    smp = {4'd0, aud[23:4]};
      default: smp = aud;
    endcase

  logic          armed, blk_on, wr_req, wr_ok, pop_ok, full;
  logic [7:0]    fidx;
  logic [191:0]  cs;
  logic [3:0]    set;
  logic [AW-1:0] wp, rp;
  logic [24:0]   mem [DEPTH];

  assign full   = (q_level == LW'(DEPTH));
  assign pop_ok = pop && q_valid;
  assign wr_req = busy && sf_done && (armed || right == !cap_left);
  assign wr_ok  = wr_req && (!full || pop_ok);
  assign set[0] = rx_en && viol;
  assign set[1] = rx_en && pre_ok && (pk_n == P_B);
  assign set[2] = busy && sf_done && !right && blk_on && (fidx == 8'd191);
  assign set[3] = wr_req && !wr_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; armed <= 1'b0; blk_on <= 1'b0; fidx <= '0;
      cs <= '0; flags <= '0; wp <= '0; rp <= '0; q_level <= '0;
    end else begin
      if (went_idle) busy <= 1'b0;
      else if (pre_ok && rx_en && !busy) begin busy <= 1'b1; armed <= 1'b0; end
      else if (busy && sf_done && right && !rx_en) busy <= 1'b0;
      if (wr_req) armed <= 1'b1;

      if (pre_ok && pk_n == P_B) begin fidx <= '0; blk_on <= 1'b1; end
      else if (sf_done && !right && blk_on) begin
        if (busy) cs[fidx] <= sr_n[26];
        if (fidx == 8'd191) blk_on <= 1'b0;
        fidx <= fidx + 8'd1;
      end

      flags <= (flags & ~clr) | set;

      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (wr_ok && !pop_ok) q_level <= q_level + LW'(1);
      else if (pop_ok && !wr_ok) q_level <= q_level - LW'(1);
    end

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {right, smp};

  assign q_valid = (q_level != '0);
  assign q_data  = mem[rp][23:0];
  assign q_right = mem[rp][24];
  assign irq     = |(flags & ie);
  assign cs_bits = cs;
endmodule

// File: rtl/spdif_rx_tracker_chk.sv
module spdif_rx_tracker_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          busy,
  input logic [3:0]    flags,
  input logic [3:0]    clr,
  input logic [3:0]    ie,
  input logic          irq,
  input logic [LW-1:0] q_level
);
  // R1
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rx_en));
  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags & ~$past(clr)) == 4'd0));
  // R11
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & ie) != 4'd0));
  // R10
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LW'(DEPTH));
  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> ($past(q_level) == LW'(DEPTH)));
endmodule

bind spdif_rx_tracker spdif_rx_tracker_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .busy(busy), .flags(flags),
  .clr(clr), .ie(ie), .irq(irq), .q_level(q_level)
);

// File: tb/spdif_rx_tracker_test.sv
module spdif_rx_tracker_test;
  localparam int HALF = 2;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [7:0] PB = 8'b11101000, PM = 8'b11100010,
                         PW = 8'b11100100, PBAD = 8'b11100110;

  logic clk = 0, rst_n = 0, line_in = 0, rx_en = 0, cap_left = 1, pop = 0;
  logic [1:0] mode = 2'd2;
  logic [3:0] clr = 0, ie = 0;
  logic q_valid, q_right, busy, irq;
  logic [23:0] q_data;
  logic [LW-1:0] q_level;
  logic [3:0] flags;
  logic [191:0] cs_bits;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spdif_rx_tracker #(.HALF(HALF), .DEPTH(DEPTH)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hb(input logic v);
    line_in = v;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pre(input logic [7:0] p);
    logic b0 = line_in;
    for (int i = 7; i >= 0; i--) hb(p[i] ? ~b0 : b0);
  endtask

  task automatic sub(input logic [7:0] p, input logic [23:0] a, input logic c);
    logic [27:0] w = {1'b0, c, 2'b00, a};
    pre(p);
    for (int i = 0; i < 28; i++) begin
      hb(~line_in);
      hb(w[i] ? ~line_in : line_in);
    end
  endtask

  task automatic tail;
    hb(~line_in);
    repeat (12 * HALF) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [23:0] d, input logic r);
    check(req, {31'd0, q_valid}, 32'd1);
    check(req, {8'd0, q_data}, {8'd0, d});
    check(req, {31'd0, q_right}, {31'd0, r});
    pop = 1; @(negedge clk); pop = 0;
  endtask

  task automatic drain;
    while (q_valid) begin pop = 1; @(negedge clk); pop = 0; end
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    clr = m; @(negedge clk); clr = 0; @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 busy", {31'd0, busy}, 0);
    check("R12 flags", {28'd0, flags}, 0);
    check("R12 irq", {31'd0, irq}, 0);
    check("R12 q_valid", {31'd0, q_valid}, 0);
  endtask

  task automatic t_lock_left;
    rx_en = 1; cap_left = 1; mode = 2'd2;
    repeat (40) @(negedge clk);
    check("R1 enable alone", {31'd0, busy}, 0);
    sub(PM, 24'h111111, 0);
    check("R1 lock", {31'd0, busy}, 1);
    sub(PW, 24'h222222, 0); sub(PM, 24'h333333, 0); sub(PW, 24'h444444, 0);
    tail;
    check("R5 level", {{(32-LW){1'b0}}, q_level}, 4);
    pop_chk("R5 first left", 24'h111111, 0);
    pop_chk("R4 right", 24'h222222, 1);
    pop_chk("R4 left", 24'h333333, 0);
    pop_chk("R4 right", 24'h444444, 1);
  endtask

  task automatic t_cap_right;
    cap_left = 0;
    sub(PM, 24'hA00001, 0); sub(PW, 24'hA00002, 0);
    sub(PM, 24'hA00003, 0); sub(PW, 24'hA00004, 0);
    tail;
    check("R5 right start level", {{(32-LW){1'b0}}, q_level}, 3);
    pop_chk("R5 first right", 24'hA00002, 1);
    pop_chk("R5 then left", 24'hA00003, 0);
    pop_chk("R5 then right", 24'hA00004, 1);
    cap_left = 1;
  endtask

  task automatic t_modes;
    mode = 2'd0;
    sub(PM, 24'hABCDEF, 0); sub(PW, 24'h123456, 0); tail;
    pop_chk("R6 mode16 left", 24'h00ABCD, 0);
    pop_chk("R6 mode16 right", 24'h001234, 1);
    mode = 2'd1;
    sub(PM, 24'hABCDEF, 0); sub(PW, 24'h123456, 0); tail;
    pop_chk("R6 mode20 left", 24'h0ABCDE, 0);
    pop_chk("R6 mode20 right", 24'h012345, 1);
    mode = 2'd2;
  endtask

  task automatic t_stop;
    sub(PM, 24'hC00001, 0);
    rx_en = 0;
    check("R2 busy held mid-frame", {31'd0, busy}, 1);
    sub(PW, 24'hC00002, 0);
    sub(PM, 24'hC00003, 0);
    check("R2 busy fell at frame end", {31'd0, busy}, 0);
    tail;
    check("R2 later subframe not queued", {{(32-LW){1'b0}}, q_level}, 2);
    pop_chk("R2 left kept", 24'hC00001, 0);
    pop_chk("R2 right kept", 24'hC00002, 1);
    rx_en = 1;
  endtask

  task automatic t_idle;
    sub(PM, 24'h5A5A5A, 0); sub(PW, 24'hA5A5A5, 0);
    hb(~line_in);
    repeat (8) @(negedge clk);
    check("R3 busy over short quiet", {31'd0, busy}, 1);
    repeat (16) @(negedge clk);
    check("R3 busy after inactivity", {31'd0, busy}, 0);
    drain;
  endtask

  task automatic t_flags;
    ie = 4'b0011;
    sub(PB, 24'h0F0F0F, 0); sub(PW, 24'hF0F0F0, 0); tail;
    check("R7 block-start flag", {28'd0, flags}, 4'b0010);
    check("R11 irq", {31'd0, irq}, 1);
    pulse_clr(4'b0010);
    check("R11 cleared", {28'd0, flags}, 0);
    check("R11 irq low", {31'd0, irq}, 0);
    drain;
    sub(PM, 24'h777777, 0);
    pre(PBAD);
    for (int i = 0; i < 28; i++) begin hb(~line_in); hb(line_in); end
    tail;
    check("R8 bad flag", {28'd0, flags}, 4'b0001);
    check("R8 subframe dropped", {{(32-LW){1'b0}}, q_level}, 1);
    pop_chk("R8 earlier kept", 24'h777777, 0);
    sub(PM, 24'h1, 0); sub(PW, 24'h2, 0); tail;
    check("R11 sticky", {28'd0, flags}, 4'b0001);
    pulse_clr(4'b0001);
    check("R11 clear bad", {28'd0, flags}, 0);
    drain;
    ie = 0;
  endtask

  task automatic t_overrun;
    ie = 4'b1000;
    for (int i = 0; i < 3; i++) begin
      sub(PM, 24'hD00000 + 24'(2 * i), 0);
      sub(PW, 24'hD00001 + 24'(2 * i), 0);
    end
    tail;
    check("R10 overrun flag", {28'd0, flags}, 4'b1000);
    check("R10 irq", {31'd0, irq}, 1);
    check("R10 level full", {{(32-LW){1'b0}}, q_level}, DEPTH);
    pop_chk("R10 oldest kept", 24'hD00000, 0);
    pop_chk("R10 order", 24'hD00001, 1);
    pop_chk("R10 order", 24'hD00002, 0);
    pop_chk("R10 order", 24'hD00003, 1);
    check("R10 newer dropped", {31'd0, q_valid}, 0);
    pulse_clr(4'b1000);
    ie = 0;
  endtask

  function automatic logic csp(input int i);
    return logic'(((i * 5) + (i / 7)) & 1);
  endfunction

  task automatic t_cs;
    logic [191:0] exp = '0;
    for (int i = 0; i < 192; i++) exp[i] = csp(i);
    for (int f = 0; f < 191; f++) begin
      sub(f == 0 ? PB : PM, 24'(f), csp(f));
      sub(PW, 24'(f), ~csp(f));
    end
    check("R9 not done before frame 191", {31'd0, flags[2]}, 0);
    sub(PM, 24'd191, csp(191));
    sub(PW, 24'd191, ~csp(191));
    tail;
    check("R9 block flag", {31'd0, flags[2]}, 1);
    check("R9 status block", {31'd0, cs_bits == exp}, 1);
    check("R9 word A", cs_bits[31:0], exp[31:0]);
    check("R9 word F", cs_bits[191:160], exp[191:160]);
    pulse_clr(4'hF);
    drain;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_lock_left;
    t_cap_right;
    t_modes;
    t_stop;
    t_idle;
    t_flags;
    t_overrun;
    t_cs;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule